// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable storage array with a fully synchronous, pipelined access interface. On each rising clock edge it samples an address, an active-low select, a read/write control and one active-low write select per 9-bit byte lane. A write supplies its data one cycle after its address. Because of this, a write can directly follow a read on the shared data bus without an idle turnaround cycle. Read data passes through two output register stages and appears on the bus two edges after its address.

A write is held in a one-entry commit register for one cycle after its data arrives. A read of the same address in that window is answered by merging the enabled lanes of the pending data over the stored word.

The data bus is modelled as separate input data, output data and an output drive enable, and the drive enable marks the cycles in which the block owns the bus. An output-disable input gates that drive enable combinationally, so it takes effect at once. A synchronous sleep input blocks new accesses. After sleep is released, a programmable number of recovery edges must pass before new accesses are accepted. The stored contents survive sleep.

The word is 36 bits (four lanes) or 18 bits (two lanes), chosen by a parameter. The depth is a power of two set by the address width.

Top module: `latewr_sram`

## Requirements
- R1: After reset, `dq_oe` is low and every address reads back as zero.
- R2: An edge with `cs_n` high starts nothing: the array is not modified and no read data is driven for that edge, whatever `rw`, `addr` and `bw_n` are.
- R3: A read (`cs_n` low, `rw` high) accepted at edge N drives the stored word on `dq_o` with `dq_oe` high during the cycle after edge N+2, provided `oe_n` is low.
- R4: A write (`cs_n` low, `rw` low) accepted at edge N takes its data from `dq_i` at edge N+1. Lane i covers bits 9i+8..9i and is replaced only if `bw_n[i]` is low. The other lanes keep their old contents.
- R5: A read accepted at any edge after a write's address edge returns that write's data, including the read that directly follows the write at the same address. Reads and writes alternate on consecutive edges with no idle cycle.
- R6: `dq_oe` is low in every cycle that does not carry the result of a read accepted three sampling edges before, which includes all write, deselect and idle slots.
- R7: While `oe_n` is high, `dq_oe` is low. The change follows `oe_n` at once, without waiting for a clock edge.
- R8: An edge at which `sleep` is high accepts no read or write.
- R9: After `sleep` falls, the first `WAKE_CYCLES` edges with `sleep` low accept no access. Accesses resume on the next edge, and all stored data is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low access select, sampled |
| rw | input | 1 | 1 = read, 0 = write, sampled |
| addr | input | ADDR_W | Word address, sampled |
| bw_n | input | LANES | Active-low per-lane write selects, sampled |
| sleep | input | 1 | Synchronous power-down request |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | WORD_W | Write data, taken one edge after the write address |
| dq_o | output | WORD_W | Read data from the second output stage |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The assertions check on every cycle that the bus drive stays off in these cases:
- three sampling edges after a deselected, write, sleeping or recovering edge;
- whenever output enable is deasserted;
- they also check that an accepted read produces a drive three sampling edges later.

Only the bench scenarios can show that the data values are right. These include lane-merged writes, forwarding from the pending commit register, that ignored writes leave the array unchanged, and that contents survive sleep. The bench checks them against a reference array that sweeps every address and every lane-select pattern.

// File: rtl/lws_pkg.sv
package lws_pkg;

    localparam int unsigned LANE_BITS = 9;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl
    import lws_pkg::*;
#(
    parameter int unsigned AW          = 4,
    parameter int unsigned NL          = 4,
    parameter int unsigned WAKE_CYCLES = 3,
    localparam int unsigned CW = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] bw_n,
    input  logic          sleep,
    output cmd_e          cmd_o,
    output logic [AW-1:0] addr_o,
    output logic [NL-1:0] bw_n_o
);

    typedef struct packed {
        cmd_e          cmd;
        logic [AW-1:0] addr;
        logic [NL-1:0] bw_n;
        logic [CW-1:0] wake;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d   = st_q;
        accept = !cs_n && !sleep && (st_q.wake == '0);
        if (accept) begin
            st_d.cmd = rw ? CMD_RD : CMD_WR;
        end else begin
            st_d.cmd = CMD_NONE;
        end
        st_d.addr = addr;
        st_d.bw_n = bw_n;
        if (sleep) begin
            st_d.wake = CW'(WAKE_CYCLES);
        end else if (st_q.wake != '0) begin
            st_d.wake = st_q.wake - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign addr_o = st_q.addr;
    assign bw_n_o = st_q.bw_n;

endmodule

// File: rtl/lws_store.sv
module lws_store
    import lws_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned NL = 4,
    localparam int unsigned DW    = NL * LANE_BITS,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NL-1:0] bw_n_i,
    input  logic [DW-1:0] wdata_i,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [NL-1:0] bw_n;
        logic [DW-1:0] data;
    } commit_t;

    commit_t       cm_d, cm_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] old_word;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] merged_word;
    logic          hit;

    assign old_word = mem_q[cm_q.addr];
    assign rd_word  = mem_q[addr_i];
    assign hit      = cm_q.valid && (cm_q.addr == addr_i);

    // Per-lane merge for the commit and for forwarding into reads
    for (genvar l = 0; l < NL; l++) begin : g_lane
        localparam int unsigned LO = l * LANE_BITS;
        assign merged_word[LO +: LANE_BITS] = cm_q.bw_n[l] ? old_word[LO +: LANE_BITS]
                                                           : cm_q.data[LO +: LANE_BITS];
        assign rd_data_o[LO +: LANE_BITS]   = (hit && !cm_q.bw_n[l]) ? cm_q.data[LO +: LANE_BITS]
                                                                     : rd_word[LO +: LANE_BITS];
    end

    always_comb begin
        cm_d.valid = (cmd_i == CMD_WR);
        cm_d.addr  = addr_i;
        cm_d.bw_n  = bw_n_i;
        cm_d.data  = wdata_i;
        mem_d      = mem_q;
        if (cm_q.valid) begin
            mem_d[cm_q.addr] = merged_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            cm_q  <= cm_d;
            mem_q <= mem_d;
        end
    end

    assign rd_valid_o = (cmd_i == CMD_RD);

endmodule

// File: rtl/lws_outpipe.sv
module lws_outpipe #(
    parameter int unsigned DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    input  logic          oe_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);

    typedef struct packed {
        logic          v1;
        logic [DW-1:0] d1;
        logic          v2;
        logic [DW-1:0] d2;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.v1 = vld_i;
        if (vld_i) begin
            st_d.d1 = data_i;
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.d2 = st_q.d1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o  = st_q.d2;
    assign dq_oe = st_q.v2 && !oe_n;

endmodule

// File: rtl/latewr_sram.sv
module latewr_sram
    import lws_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter bit          WIDE_WORD   = 1'b1,
    parameter int unsigned WAKE_CYCLES = 3,
    localparam int unsigned LANES  = WIDE_WORD ? 4 : 2,
    localparam int unsigned WORD_W = LANES * LANE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);

    cmd_e              cmd;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_bw_n;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_data;

    lws_ctrl #(
        .AW          (ADDR_W),
        .NL          (LANES),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rw     (rw),
        .addr   (addr),
        .bw_n   (bw_n),
        .sleep  (sleep),
        .cmd_o  (cmd),
        .addr_o (cmd_addr),
        .bw_n_o (cmd_bw_n)
    );

    lws_store #(
        .AW (ADDR_W),
        .NL (LANES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .addr_i     (cmd_addr),
        .bw_n_i     (cmd_bw_n),
        .wdata_i    (dq_i),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    lws_outpipe #(
        .DW (WORD_W)
    ) u_outpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (rd_valid),
        .data_i (rd_data),
        .oe_n   (oe_n),
        .dq_o   (dq_o),
        .dq_oe  (dq_oe)
    );

endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
    parameter int unsigned WAKE_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rw,
    input logic sleep,
    input logic oe_n,
    input logic dq_oe
);

    // Recovery window tracked independently of the design
    int unsigned quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= 0;
        end else if (sleep) begin
            quiet_q <= WAKE_CYCLES;
        end else if (quiet_q != 0) begin
            quiet_q <= quiet_q - 1;
        end
    end

    a_r2_deselect_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> ##3 !dq_oe);

    a_r6_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rw) |-> ##3 !dq_oe);

    a_r8_sleep_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ##3 !dq_oe);

    a_r9_recovery_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q != 0) |-> ##3 !dq_oe);

    a_r7_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw && !sleep && quiet_q == 0) |-> ##3 (dq_oe || oe_n));

endmodule

bind latewr_sram lws_checker #(
    .WAKE_CYCLES (WAKE_CYCLES)
) u_lws_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .rw    (rw),
    .sleep (sleep),
    .oe_n  (oe_n),
    .dq_oe (dq_oe)
);

// File: tb/test_latewr_sram.sv
module test_latewr_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int NL    = 4;
    localparam int DW    = NL * 9;
    localparam int DEPTH = 1 << AW;
    localparam int WAKE  = 3;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n  = 1'b1;
    logic          rw    = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [NL-1:0] bw_n  = '1;
    logic          sleep = 1'b0;
    logic          oe_n  = 1'b0;
    logic [DW-1:0] dq_i  = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    latewr_sram #(
        .ADDR_W      (AW),
        .WIDE_WORD   (1'b1),
        .WAKE_CYCLES (WAKE)
    ) i_latewr_sram (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .rw    (rw),
        .addr  (addr),
        .bw_n  (bw_n),
        .sleep (sleep),
        .oe_n  (oe_n),
        .dq_i  (dq_i),
        .dq_o  (dq_o),
        .dq_oe (dq_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic          pend_v = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [NL-1:0] pend_b = '1;
    logic          p0v = 1'b0, p1v = 1'b0, p2v = 1'b0;
    logic [DW-1:0] p0d = '0, p1d = '0, p2d = '0;
    int            wake_m = 0;
    logic [DW-1:0] carry = '0;
    string         out_tag = "R1";

    function automatic logic [DW-1:0] pat(input int k);
        return {4'(k ^ 5), 32'(k * 32'h9E3779B9 + 32'h01234567)};
    endfunction

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s dq_oe actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_word(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s dq_o actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: check outputs, drive inputs, advance the model
    task automatic step(input logic c_n, input logic r, input logic [AW-1:0] a,
                        input logic [NL-1:0] b, input logic [DW-1:0] wd, input logic slp);
        logic acc;
        @(negedge clk);
        chk_bit(out_tag, dq_oe, p2v && !oe_n);
        if (p2v && !oe_n) chk_word(out_tag, dq_o, p2d);
        cs_n  = c_n;
        rw    = r;
        addr  = a;
        bw_n  = b;
        sleep = slp;
        dq_i  = carry;
        carry = wd;
        @(posedge clk);
        if (pend_v) begin
            for (int l = 0; l < NL; l++) begin
                if (!pend_b[l]) ref_mem[pend_a][l*9 +: 9] = dq_i[l*9 +: 9];
            end
        end
        acc    = !c_n && !slp && (wake_m == 0);
        pend_v = acc && !r;
        pend_a = a;
        pend_b = b;
        p2v = p1v; p2d = p1d;
        p1v = p0v; p1d = p0d;
        p0v = acc && r;
        p0d = ref_mem[a];
        if (slp) wake_m = WAKE;
        else if (wake_m > 0) wake_m--;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] b, input logic [DW-1:0] wd);
        step(1'b0, 1'b0, a, b, wd, 1'b0);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        step(1'b0, 1'b1, a, '1, pat(int'(a) + 999), 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0, '1, pat(i + 777), 1'b0);
    endtask

    task automatic read_all();
        for (int a = 0; a < DEPTH; a++) rd(AW'(a));
        idle(3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and cleared contents
        chk_bit("R1", dq_oe, 1'b0);
        out_tag = "R1";
        read_all();

        // R3/R4: full-word fill with back-to-back writes, then read back
        out_tag = "R3";
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0, pat(a));
        read_all();

        // R5: write then read same address on the next edge, no idle
        out_tag = "R5";
        for (int i = 0; i < 2 * DEPTH; i++) begin
            wr(AW'(i), '0, pat(100 + i));
            rd(AW'(i));
            rd(AW'(i) ^ AW'(1));
        end
        idle(3);

        // R6: strict read/write alternation over distinct addresses
        out_tag = "R6";
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i));
            wr(AW'(DEPTH - 1 - i), '0, pat(150 + i));
        end
        idle(3);
        read_all();

        // R4: every lane-select pattern on one address
        out_tag = "R4";
        for (int b = 0; b < (1 << NL); b++) begin
            wr(AW'(5), NL'(b), pat(200 + b));
            rd(AW'(5));
        end
        idle(3);

        // R2: deselected writes and reads have no effect
        out_tag = "R2";
        for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, AW'(a), '0, pat(300 + a), 1'b0);
        for (int a = 0; a < 4; a++) step(1'b1, 1'b1, AW'(a), '1, pat(350 + a), 1'b0);
        idle(3);
        read_all();

        // R7: reads with output disabled, then asynchronous gating
        out_tag = "R7";
        oe_n = 1'b1;
        for (int a = 0; a < 4; a++) rd(AW'(a));
        idle(3);
        oe_n = 1'b0;
        rd(AW'(7));
        idle(2);
        #2;
        chk_bit("R7", dq_oe, 1'b1);
        oe_n = 1'b1;
        #1;
        chk_bit("R7", dq_oe, 1'b0);
        oe_n = 1'b0;
        #1;
        chk_bit("R7", dq_oe, 1'b1);
        chk_word("R7", dq_o, ref_mem[7]);
        idle(3);

        // R8: accesses during sleep are ignored
        out_tag = "R8";
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b0, AW'(a), '0, pat(400 + a), 1'b1);
        for (int a = 0; a < 4; a++) step(1'b0, 1'b1, AW'(a), '1, pat(450 + a), 1'b1);

        // R9: recovery edges ignore writes, then writes resume
        out_tag = "R9";
        for (int k = 0; k < WAKE + 3; k++) wr(AW'(k), '0, pat(500 + k));
        idle(3);
        read_all();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule